// File: doc/BRIEF.md
# Shared-Tick Input Debounce Bank

This block cleans up to 32 general-purpose input pins before they reach edge and level detection. Every pin first crosses into the bus clock domain through a two-stage synchronizer. A single prescaler, shared by all pins, counts bus clocks and fires a sampling tick once per programmed divisor. A pin whose filter is switched on takes a new level only after two consecutive ticks have sampled that same level. Shorter disturbances never reach its output.

Filtering runs on a pin only when two conditions hold: its debounce enable bit is set, and the neighbouring interrupt logic reports that the pin's interrupt is enabled (`pin_irq_en`). Any other pin passes its synchronized input straight through. Software programs the enable mask and the 24-bit divisor through a small register port, and can read back the cleaned pin levels. Because the divisor is shared, every filtered pin has the same debounce interval. Reset clears the enable mask and the divisor.

Top module: `dbnc_bank`

## Requirements
- R1: After a synchronous active-low reset, the enable mask and the divisor read as zero, and every bit of `pin_clean` is 0.
- R2: A write to byte address 0x40 loads the enable mask, one bit per pin, with bit i for pin i. A read of 0x40 returns the mask in the next cycle after the write.
- R3: A write to byte address 0x44 stores the low 24 bits of the write data as the divisor. A read of 0x44 returns those bits, with bits 31:24 reading 0.
- R4: With a divisor N of 2 or more, the sampling tick fires once every N clocks, and a divisor write restarts the count. A divisor of 0 or 1 produces a tick on every clock.
- R5: A pin whose enable bit or `pin_irq_en` bit is 0 drives `pin_clean` with its raw input delayed by exactly two clocks.
- R6: On a pin with both bits set, `pin_clean` takes a new level only after two consecutive ticks have sampled that level. A disturbance seen by fewer than two consecutive ticks leaves the output unchanged.
- R7: A read of byte address 0x48 returns the current `pin_clean` vector.
- R8: Writes to any other address change neither the mask nor the divisor, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_raw | input | 32 | Asynchronous raw pin levels |
| pin_irq_en | input | 32 | Per-pin interrupt enable from the detection logic |
| pin_clean | output | 32 | Debounced or synchronized pin levels |

## Verification
A wrong prescaler count shows up on the first filtered edge: a filtered pin settles too early or too late, within at most two divisor periods of the input change. A corrupted per-pin sample shows up as a glitch that is let through or as a stable level that is missed. A bypassed pin that is accidentally gated shows up within two clocks as a lost synchronizer delay. A cycle-accurate model in the bench compares both outputs on every clock, so any of these errors is reported in the cycle it first appears.

// File: rtl/dbnc_pkg.sv
// Shared constants and types for the debounce bank.
// Assumes a byte-addressed register port with 32-bit data.
package dbnc_pkg;

    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned PRESCL_W  = 24;

    localparam logic [ADDR_W-1:0] ADR_ENABLE = 8'h40;
    localparam logic [ADDR_W-1:0] ADR_DIVIDE = 8'h44;
    localparam logic [ADDR_W-1:0] ADR_LEVELS = 8'h48;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_DIVIDE = 2'd2,
        SEL_LEVELS = 2'd3
    } reg_sel_e;

    // Map a byte address onto a register selector.
    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADR_ENABLE: return SEL_ENABLE;
            ADR_DIVIDE: return SEL_DIVIDE;
            ADR_LEVELS: return SEL_LEVELS;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dbnc_sync.sv
// Two-flop synchronizer bank: brings asynchronous pin levels into the bus
// clock domain. Assumes inputs may change at any time; output lags by 2 clocks.
module dbnc_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift raw levels through two capture stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/dbnc_prescaler.sv
// Shared sampling-tick generator: divides the bus clock by a programmed count.
// Assumes restart is pulsed in the cycle the divisor register is written.
// A divisor of 0 or 1 yields a tick every clock.
module dbnc_prescaler #(
    parameter int unsigned CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] divisor,
    input  logic             restart,
    output logic             tick
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    // Terminal count reached, or the divisor is too small to count.
    always_comb begin
        if (divisor <= ONE) begin
            at_limit = 1'b1;
        end else begin
            at_limit = (cnt_q >= (divisor - ONE));
        end
    end

    assign tick = at_limit;

    // Advance the count, reload on the tick, restart on a divisor write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/dbnc_lane.sv
// One pin's debounce filter. On each tick it compares the new sample with the
// one from the previous tick and adopts the level when both agree. While the
// lane is inactive, both registers track the synchronized input so that
// enabling the filter does not produce a step.
module dbnc_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick,
    input  logic level_in,
    output logic filt_out
);

    logic last_sample_q;
    logic filt_q;

    // Sample on ticks and accept a level seen on two ticks in a row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_sample_q <= 1'b0;
            filt_q        <= 1'b0;
        end else if (!active) begin
            last_sample_q <= level_in;
            filt_q        <= level_in;
        end else if (tick) begin
            last_sample_q <= level_in;
            if (level_in == last_sample_q) begin
                filt_q <= level_in;
            end
        end
    end

    assign filt_out = filt_q;

endmodule

// File: rtl/dbnc_bank.sv
// Debounce bank top: register port, shared prescaler, per-pin synchronizers
// and filter lanes. Assumes one write per strobe cycle and that pin_irq_en
// comes from the interrupt detection logic in the same clock domain.
module dbnc_bank
    import dbnc_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NPIN-1:0]     pin_raw,
    input  logic [NPIN-1:0]     pin_irq_en,
    output logic [NPIN-1:0]     pin_clean
);

    reg_sel_e              sel;
    logic                  wr_enable;
    logic                  wr_divide;
    logic [NPIN-1:0]       en_q;
    logic [PRESCL_W-1:0]   div_q;
    logic                  tick;
    logic [NPIN-1:0]       sync_v;
    logic [NPIN-1:0]       filt_v;
    logic [NPIN-1:0]       active_v;

    assign sel       = decode_addr(bus_addr);
    assign wr_enable = bus_wr && (sel == SEL_ENABLE);
    assign wr_divide = bus_wr && (sel == SEL_DIVIDE);

    // Hold the enable mask and divisor written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            div_q <= '0;
        end else begin
            if (wr_enable) begin
                en_q <= bus_wdata[NPIN-1:0];
            end
            if (wr_divide) begin
                div_q <= bus_wdata[PRESCL_W-1:0];
            end
        end
    end

    dbnc_prescaler #(
        .CNT_W (PRESCL_W)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_q),
        .restart (wr_divide),
        .tick    (tick)
    );

    dbnc_sync #(
        .WIDTH (NPIN)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_raw),
        .sync_out (sync_v)
    );

    assign active_v = en_q & pin_irq_en;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_lane
        dbnc_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (active_v[gi]),
            .tick     (tick),
            .level_in (sync_v[gi]),
            .filt_out (filt_v[gi])
        );
    end

    // Pick the filtered level on active pins, the synchronized one elsewhere.
    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            pin_clean[i] = active_v[i] ? filt_v[i] : sync_v[i];
        end
    end

    // Return the selected register, zero-extended to the bus width.
    always_comb begin
        case (sel)
            SEL_ENABLE: bus_rdata = DATA_W'(en_q);
            SEL_DIVIDE: bus_rdata = DATA_W'(div_q);
            SEL_LEVELS: bus_rdata = DATA_W'(pin_clean);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dbnc_bank_chk.sv
// Property checker for dbnc_bank, attached with bind below.
module dbnc_bank_chk
    import dbnc_pkg::*;
#(
    parameter int unsigned NPIN = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NPIN-1:0]     pin_clean,
    input logic [NPIN-1:0]     en_q,
    input logic [PRESCL_W-1:0] div_q,
    input logic                tick,
    input logic [NPIN-1:0]     sync_v,
    input logic [NPIN-1:0]     filt_v,
    input logic [NPIN-1:0]     active_v
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_q == '0 && div_q == '0));

    // R2
    enable_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADR_ENABLE) |=> (en_q == $past(bus_wdata[NPIN-1:0])));

    // R3
    divide_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADR_DIVIDE) |-> (bus_rdata[DATA_W-1:PRESCL_W] == '0));

    // R4
    small_div_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q <= PRESCL_W'(1)) |-> tick);

    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_q >= PRESCL_W'(2) && !(bus_wr && bus_addr == ADR_DIVIDE)) |=> !tick);

    // R5
    bypass_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_clean ^ sync_v) & ~active_v) == '0);

    // R6
    filter_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((filt_v ^ $past(filt_v)) & $past(active_v)) != '0) |-> $past(tick));

    // R8
    stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADR_ENABLE && bus_addr != ADR_DIVIDE)
            |=> ($stable(en_q) && $stable(div_q)));

endmodule

bind dbnc_bank dbnc_bank_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_clean (pin_clean),
    .en_q      (en_q),
    .div_q     (div_q),
    .tick      (tick),
    .sync_v    (sync_v),
    .filt_v    (filt_v),
    .active_v  (active_v)
);

// File: tb/test_dbnc_bank.sv
module test_dbnc_bank;

    localparam int NPIN = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NPIN-1:0] pin_raw = '0;
    logic [NPIN-1:0] pin_irq_en = '0;
    logic [NPIN-1:0] pin_clean;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dbnc_bank #(.NPIN(NPIN)) i_dbnc_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_raw    (pin_raw),
        .pin_irq_en (pin_irq_en),
        .pin_clean  (pin_clean)
    );

    // Behavioural reference state.
    logic [NPIN-1:0] m_en, m_s1, m_s2, m_samp, m_filt;
    int m_div, m_cnt;

    function automatic logic [NPIN-1:0] m_out();
        logic [NPIN-1:0] o;
        for (int i = 0; i < NPIN; i++)
            o[i] = (m_en[i] && pin_irq_en[i]) ? m_filt[i] : m_s2[i];
        return o;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h40: return 32'(m_en);
            8'h44: return 32'(m_div);
            8'h48: return 32'(m_out());
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_s1 = '0; m_s2 = '0; m_samp = '0; m_filt = '0;
            m_div = 0; m_cnt = 0;
        end else begin
            bit tk;
            tk = (m_div <= 1) || (m_cnt >= m_div - 1);
            for (int i = 0; i < NPIN; i++) begin
                if (!(m_en[i] && pin_irq_en[i])) begin
                    m_samp[i] = m_s2[i];
                    m_filt[i] = m_s2[i];
                end else if (tk) begin
                    if (m_s2[i] == m_samp[i]) m_filt[i] = m_s2[i];
                    m_samp[i] = m_s2[i];
                end
            end
            m_s2 = m_s1;
            m_s1 = pin_raw;
            if (bus_wr && bus_addr == 8'h44) m_cnt = 0;
            else m_cnt = tk ? 0 : m_cnt + 1;
            if (bus_wr && bus_addr == 8'h40) m_en = bus_wdata[NPIN-1:0];
            if (bus_wr && bus_addr == 8'h44) m_div = int'(bus_wdata[23:0]);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare both outputs against the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 R5 R6 pin_clean", 32'(pin_clean), 32'(m_out()));
            case (bus_addr)
                8'h40: check("R2 rdata", bus_rdata, m_read(bus_addr));
                8'h44: check("R3 rdata", bus_rdata, m_read(bus_addr));
                8'h48: check("R7 rdata", bus_rdata, m_read(bus_addr));
                default: check("R8 rdata", bus_rdata, m_read(bus_addr));
            endcase
        end
    end

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk); #1;
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1: reset state
        check("R1 pin_clean", 32'(pin_clean), 32'h0);
        rd_check("R1 enable", 8'h40, 32'h0);
        rd_check("R1 divisor", 8'h44, 32'h0);

        // R2 and R3: register load and readback
        wr(8'h40, 32'h0000_000F);
        rd_check("R2 enable", 8'h40, 32'h0000_000F);
        wr(8'h44, 32'hAB12_3456);
        rd_check("R3 divisor", 8'h44, 32'h0012_3456);

        // R8: stray write and stray read
        wr(8'h4C, 32'hFFFF_FFFF);
        rd_check("R8 enable kept", 8'h40, 32'h0000_000F);
        rd_check("R8 divisor kept", 8'h44, 32'h0012_3456);
        rd_check("R8 unknown read", 8'h4C, 32'h0);

        // R5: pin 1 enabled but interrupt off, pin 4 not enabled
        pin_irq_en = 32'h0000_0005;
        step(3);
        pin_raw[1] = 1'b1; pin_raw[4] = 1'b1;
        step(1);
        check("R5 one clock", 32'(pin_clean[1] | pin_clean[4]), 32'h0);
        step(1);
        check("R5 two clocks pin1", 32'(pin_clean[1]), 32'h1);
        check("R5 two clocks pin4", 32'(pin_clean[4]), 32'h1);

        // R6: glitch suppression with divisor 8 on active pin 0
        wr(8'h44, 32'd8);
        step(20);
        pin_raw[0] = 1'b1;
        step(2);
        pin_raw[0] = 1'b0;
        step(40);
        check("R6 glitch blocked", 32'(pin_clean[0]), 32'h0);

        // R6: steady level is taken after two ticks
        pin_raw[0] = 1'b1;
        step(3);
        check("R6 not yet", 32'(pin_clean[0]), 32'h0);
        step(30);
        check("R6 settled", 32'(pin_clean[0]), 32'h1);
        rd_check("R7 levels", 8'h48, 32'(pin_clean));

        // R4: divisor 0 ticks every clock, settle after four clocks
        wr(8'h44, 32'd0);
        step(4);
        pin_raw[2] = 1'b1;
        step(3);
        check("R4 div0 three clocks", 32'(pin_clean[2]), 32'h0);
        step(1);
        check("R4 div0 four clocks", 32'(pin_clean[2]), 32'h1);

        // Mixed phase: random levels, masks and divisors, model compared each clock.
        for (int n = 0; n < 3000; n++) begin
            step(1);
            if ($urandom_range(0, 9) == 0) pin_raw[$urandom_range(0, NPIN-1)] ^= 1'b1;
            if ($urandom_range(0, 199) == 0) pin_irq_en = $urandom;
            if ($urandom_range(0, 299) == 0) wr(8'h40, $urandom);
            if ($urandom_range(0, 399) == 0) wr(8'h44, 32'($urandom_range(0, 6)));
            if ($urandom_range(0, 49) == 0) bus_addr = 8'(8'h40 + 4 * $urandom_range(0, 3));
        end
        step(2);
        finish_run();
    end

endmodule